// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block decodes the control pins of a pipelined synchronous burst SRAM with no bus latency. It samples them on every rising clock edge and classifies the cycle. The possible classes are deselect, read begin, read continue, write begin, write continue, write abort, stall and sleep. From that class it drives registered strobes toward the memory array: a read strobe, a write strobe with per-byte lane enables, an address-load pulse and a burst-advance pulse. It also drives the enable for the tri-state driver of the bidirectional data bus.

A burst starts when the load/continue pin is low and all three chip selects agree. While that pin is high, the chip selects and the write-enable pin are ignored, and the cycle repeats the operation that a registered last-operation state remembers. During a write burst each beat takes its byte lanes from the byte-select pins of that beat. The output-enable pin is not sampled: it gates the bus driver combinationally. This makes a read with output enable off a dummy read. A clock-enable pin freezes the internal state. A sleep pin overrides everything else, and it enters and leaves sleep through a fixed number of clock edges set by parameters (2 and 2 by default).

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, every strobe and the bus drive are 0 and the cycle kind is 0, even with output enable low; the sleep flag is 0.
- R2: With load/continue low, the chip is selected only when sel_a_n=0, sel_b=1 and sel_c_n=0. Any other combination gives kind 0 (deselect), no strobes, and last operation idle.
- R3: With load/continue low, the chip selected and wr_n=1, the next cycle shows kind 1, arr_rd=1 and addr_load=1, and the bus becomes owned for reading.
- R4: With load/continue low, the chip selected, wr_n=0 and at least one lane_sel_n bit 0, the next cycle shows kind 3, arr_wr=1, addr_load=1 and lane_we equal to the bitwise inverse of lane_sel_n (bit i is lane i). The bus is not driven even with output enable low.
- R5: With wr_n=0 and all lane_sel_n bits 1, the cycle is a write abort (kind 5): arr_wr=0 and lane_we=0. A begin abort has addr_load=0 and burst_adv=0. An abort inside a write burst has burst_adv=1. Either kind leaves the last operation as write.
- R6: With load/continue high, the chip selects and wr_n are ignored. After a read, the cycle is kind 2 with arr_rd=1 and burst_adv=1. After a write, it is kind 4 with arr_wr=1, burst_adv=1 and lane_we taken from the current lane_sel_n. After a deselect, it is kind 0 with no strobes.
- R7: bus_drive is 1 exactly when the last non-stalled cycle was a read, out_en_n is 0 and sleep_req is 0. It follows out_en_n without a clock edge.
- R8: With clk_en_n=1 (and no sleep), the cycle is kind 6 with all strobes 0. The last operation and bus ownership hold, so a following continue resumes the held operation.
- R9: sleep_req=1 at an edge overrides all other pins, including clk_en_n: the cycle is kind 7 with no strobes, and the last operation and bus ownership clear. bus_drive drops as soon as sleep_req rises.
- R10: The asleep flag rises after the second consecutive edge with sleep_req=1. A single edge with sleep_req=1 followed by sleep_req=0 does not enter sleep.
- R11: After sleep_req falls, the first two edges are still kind 7 with no strobes, asleep falls after the first of them, and the third edge executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cont_burst | input | 1 | 1: continue burst, 0: load new operation |
| wr_n | input | 1 | Write enable, active low |
| lane_sel_n | input | NBYTES | Per-byte write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| clk_en_n | input | 1 | Clock enable, active low (1 stalls) |
| sleep_req | input | 1 | Sleep request, active high |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe |
| lane_we | output | NBYTES | Byte-lane write enables |
| addr_load | output | 1 | Load external address into burst counter |
| burst_adv | output | 1 | Advance burst counter |
| cyc_kind | output | 3 | Class of the last executed edge (codes in R2 to R9) |
| bus_drive | output | 1 | Data bus driver enable |
| asleep | output | 1 | Sleep state reached |

## Verification
The hardest states to reach are the ones that depend on history rather than on the current pins. One is a continue beat that lands after a stall, an abort or a sleep episode, where the correct result hinges on what the last-operation register kept or lost. The stimulus table chains its rows on purpose to reach these. It places a stall inside a read burst and a stall inside a write burst. It follows a begin abort with a writing continue, and it follows a deselect with a continue that carries scrambled chip selects. The directed part then drives a sleep request during a stalled read. It walks the full entry and recovery windows, and it ends with a continue right after an aborted sleep entry to show that the burst history was cleared.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } last_op_e;

    typedef enum logic [2:0] {
        K_DESEL    = 3'd0,
        K_RD_BEGIN = 3'd1,
        K_RD_CONT  = 3'd2,
        K_WR_BEGIN = 3'd3,
        K_WR_CONT  = 3'd4,
        K_WR_ABORT = 3'd5,
        K_STALL    = 3'd6,
        K_SLEEP    = 3'd7
    } cyc_kind_e;

    typedef enum logic [1:0] {
        SL_AWAKE  = 2'd0,
        SL_ENTER  = 2'd1,
        SL_ASLEEP = 2'd2,
        SL_WAKE   = 2'd3
    } sleep_st_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      rd;
        logic      wr;
        logic      ld;
        logic      badv;
        logic      own_bus;
        logic      hold;
        last_op_e  next_op;
    } cyc_dec_t;

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

endpackage

// File: rtl/sram_cyc_sleep.sv
module sram_cyc_sleep
    import sram_cyc_pkg::*;
#(
    parameter int SLEEP_IN_CYC  = 2,
    parameter int SLEEP_OUT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic block_ops,
    output logic asleep
);
    localparam int MAXC = (SLEEP_IN_CYC > SLEEP_OUT_CYC) ? SLEEP_IN_CYC : SLEEP_OUT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    sleep_st_e       st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   cnt_inc;

    assign cnt_inc = cnt_q + CW'(1);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            SL_AWAKE: begin
                if (sleep_req) begin
                    st_d  = (SLEEP_IN_CYC <= 1) ? SL_ASLEEP : SL_ENTER;
                    cnt_d = CW'(1);
                end
            end
            SL_ENTER: begin
                if (!sleep_req) begin
                    st_d  = SL_AWAKE;
                    cnt_d = '0;
                end else if (cnt_inc >= CW'(SLEEP_IN_CYC)) begin
                    st_d  = SL_ASLEEP;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            SL_ASLEEP: begin
                if (!sleep_req) begin
                    st_d  = (SLEEP_OUT_CYC <= 1) ? SL_AWAKE : SL_WAKE;
                    cnt_d = CW'(1);
                end
            end
            default: begin
                if (sleep_req) begin
                    st_d  = SL_ASLEEP;
                    cnt_d = '0;
                end else if (cnt_inc >= CW'(SLEEP_OUT_CYC)) begin
                    st_d  = SL_AWAKE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SL_AWAKE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign asleep    = (st_q == SL_ASLEEP);
    assign block_ops = sleep_req || (st_q == SL_ASLEEP) || (st_q == SL_WAKE);

    assert_entry_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(sleep_req));

    assert_exit_needs_release_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> !$past(sleep_req));

endmodule

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cont_burst,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] lane_sel_n,
    input  logic              clk_en_n,
    input  logic              block_ops,
    input  last_op_e          last_op,
    output cyc_dec_t          dec,
    output logic [NBYTES-1:0] lanes
);
    logic no_lane;
    assign no_lane = &lane_sel_n;

    always_comb begin
        dec.kind    = K_DESEL;
        dec.rd      = 1'b0;
        dec.wr      = 1'b0;
        dec.ld      = 1'b0;
        dec.badv    = 1'b0;
        dec.own_bus = 1'b0;
        dec.hold    = 1'b0;
        dec.next_op = OP_IDLE;
        lanes       = '0;

        if (block_ops) begin
            dec.kind = K_SLEEP;
        end else if (clk_en_n) begin
            dec.kind    = K_STALL;
            dec.hold    = 1'b1;
            dec.next_op = last_op;
        end else if (!cont_burst) begin
            if (!chip_selected(sel_a_n, sel_b, sel_c_n)) begin
                dec.kind = K_DESEL;
            end else if (wr_n) begin
                dec.kind    = K_RD_BEGIN;
                dec.rd      = 1'b1;
                dec.ld      = 1'b1;
                dec.own_bus = 1'b1;
                dec.next_op = OP_READ;
            end else if (no_lane) begin
                dec.kind    = K_WR_ABORT;
                dec.next_op = OP_WRITE;
            end else begin
                dec.kind    = K_WR_BEGIN;
                dec.wr      = 1'b1;
                dec.ld      = 1'b1;
                dec.next_op = OP_WRITE;
                lanes       = ~lane_sel_n;
            end
        end else begin
            case (last_op)
                OP_READ: begin
                    dec.kind    = K_RD_CONT;
                    dec.rd      = 1'b1;
                    dec.badv    = 1'b1;
                    dec.own_bus = 1'b1;
                    dec.next_op = OP_READ;
                end
                OP_WRITE: begin
                    dec.badv    = 1'b1;
                    dec.next_op = OP_WRITE;
                    if (no_lane) begin
                        dec.kind = K_WR_ABORT;
                    end else begin
                        dec.kind = K_WR_CONT;
                        dec.wr   = 1'b1;
                        lanes    = ~lane_sel_n;
                    end
                end
                default: dec.kind = K_DESEL;
            endcase
        end
    end

endmodule

// File: rtl/sram_cyc_regs.sv
module sram_cyc_regs
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_dec_t          dec,
    input  logic [NBYTES-1:0] lanes,
    output last_op_e          last_op,
    output logic              rd_own,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic [NBYTES-1:0] lane_we,
    output logic              addr_load,
    output logic              burst_adv,
    output cyc_kind_e         kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            last_op   <= OP_IDLE;
            rd_own    <= 1'b0;
            arr_rd    <= 1'b0;
            arr_wr    <= 1'b0;
            lane_we   <= '0;
            addr_load <= 1'b0;
            burst_adv <= 1'b0;
            kind      <= K_DESEL;
        end else begin
            arr_rd    <= dec.rd;
            arr_wr    <= dec.wr;
            lane_we   <= lanes;
            addr_load <= dec.ld;
            burst_adv <= dec.badv;
            kind      <= dec.kind;
            if (!dec.hold) begin
                last_op <= dec.next_op;
                rd_own  <= dec.own_bus;
            end
        end
    end

    assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(arr_rd && arr_wr));

    assert_wr_has_lane_R4: assert property (@(posedge clk) disable iff (rst)
        arr_wr |-> (lane_we != '0));

    assert_no_wr_no_lane_R5: assert property (@(posedge clk) disable iff (rst)
        !arr_wr |-> (lane_we == '0));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES        = 2,
    parameter int SLEEP_IN_CYC  = 2,
    parameter int SLEEP_OUT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cont_burst,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] lane_sel_n,
    input  logic              out_en_n,
    input  logic              clk_en_n,
    input  logic              sleep_req,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic [NBYTES-1:0] lane_we,
    output logic              addr_load,
    output logic              burst_adv,
    output logic [2:0]        cyc_kind,
    output logic              bus_drive,
    output logic              asleep
);
    logic              block_ops;
    last_op_e          last_op;
    logic              rd_own;
    cyc_dec_t          dec;
    logic [NBYTES-1:0] dec_lanes;
    cyc_kind_e         kind_q;

    sram_cyc_sleep #(
        .SLEEP_IN_CYC (SLEEP_IN_CYC),
        .SLEEP_OUT_CYC(SLEEP_OUT_CYC)
    ) u_sleep (
        .clk      (clk),
        .rst      (rst),
        .sleep_req(sleep_req),
        .block_ops(block_ops),
        .asleep   (asleep)
    );

    sram_cyc_decode #(.NBYTES(NBYTES)) u_decode (
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .cont_burst(cont_burst),
        .wr_n      (wr_n),
        .lane_sel_n(lane_sel_n),
        .clk_en_n  (clk_en_n),
        .block_ops (block_ops),
        .last_op   (last_op),
        .dec       (dec),
        .lanes     (dec_lanes)
    );

    sram_cyc_regs #(.NBYTES(NBYTES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .lanes    (dec_lanes),
        .last_op  (last_op),
        .rd_own   (rd_own),
        .arr_rd   (arr_rd),
        .arr_wr   (arr_wr),
        .lane_we  (lane_we),
        .addr_load(addr_load),
        .burst_adv(burst_adv),
        .kind     (kind_q)
    );

    assign cyc_kind  = kind_q;
    assign bus_drive = rd_own && !out_en_n && !sleep_req;

    assert_write_no_bus_R4: assert property (@(posedge clk) disable iff (rst)
        arr_wr |-> !bus_drive);

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_en_n && !block_ops) |=> (!arr_rd && !arr_wr && $stable(rd_own) && $stable(last_op)));

    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (!arr_rd && !arr_wr && !rd_own && last_op == OP_IDLE));

    assert_sleep_tristate_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !bus_drive);

    assert_asleep_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (!arr_rd && !arr_wr && !addr_load));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a_n, sel_b, sel_c_n, cont_burst, wr_n, out_en_n, clk_en_n, sleep_req;
    logic [1:0] lane_sel_n;
    logic       arr_rd, arr_wr, addr_load, burst_adv, bus_drive, asleep;
    logic [1:0] lane_we;
    logic [2:0] cyc_kind;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sram_cycle_ctrl u_dut (
        .clk(clk), .rst(rst),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cont_burst(cont_burst), .wr_n(wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .clk_en_n(clk_en_n), .sleep_req(sleep_req),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .lane_we(lane_we),
        .addr_load(addr_load), .burst_adv(burst_adv), .cyc_kind(cyc_kind),
        .bus_drive(bus_drive), .asleep(asleep)
    );

    // inputs {a_n,b,c_n,cont,wr_n,lanes_n[1:0],oe_n,cen_n,sleep}
    // expected {kind[2:0],rd,wr,lane_we[1:0],ld,adv,bus}
    localparam int NV = 20;
    localparam logic [19:0] VEC [0:NV-1] = '{
        20'b1100111000_0000000000,
        20'b0011111000_0000000000,
        20'b0000111000_0000000000,
        20'b0110111000_0000000000,
        20'b0100111000_0011000101,
        20'b1011111000_0101000011,
        20'b0101111100_0101000010,
        20'b0101111010_1100000001,
        20'b0101000000_0101000011,
        20'b0100111100_0011000100,
        20'b0100010000_0110101100,
        20'b1111101000_1000110010,
        20'b0101011000_1010000010,
        20'b0101100000_1000111010,
        20'b0100011000_1010000000,
        20'b0101000000_1000111010,
        20'b0101000010_1100000000,
        20'b1100111000_0000000000,
        20'b0100111010_1100000000,
        20'b0100111000_0011000101
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] v);
        {sel_a_n, sel_b, sel_c_n, cont_burst, wr_n, lane_sel_n, out_en_n, clk_en_n, sleep_req} = v;
    endtask

    task automatic step;
        @(posedge clk);
        #5;
    endtask

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd3: return "R4";
            3'd5: return "R5";
            3'd6: return "R8";
            3'd7: return "R9";
            default: return "R6";
        endcase
    endfunction

    localparam logic [9:0] RD_BEGIN = 10'b0100111000;

    initial begin
        drive(RD_BEGIN);
        out_en_n = 1'b0;
        // R1: reset state, output enable low
        step;
        step;
        chk("R1 strobes", {cyc_kind, arr_rd, arr_wr, lane_we, addr_load, burst_adv}, 0);
        chk("R1 bus", {bus_drive, asleep}, 0);
        @(negedge clk);
        rst = 1'b0;
        drive(10'b0100111000 | 10'b0001000000); // continue with no history
        step;
        chk("R1 first edge", {cyc_kind, arr_rd, arr_wr, bus_drive}, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][19:10]);
            step;
            chk(tag_of(VEC[i][9:7]),
                {cyc_kind, arr_rd, arr_wr, lane_we, addr_load, burst_adv},
                {22'd0, VEC[i][9:1]});
            chk("R7 bus", {31'd0, bus_drive}, {31'd0, VEC[i][0]});
        end

        // R9: sleep during a stalled read; bus drops before any edge
        @(negedge clk);
        drive(RD_BEGIN | 10'b0000000011);
        #5;
        chk("R9 async tristate", {31'd0, bus_drive}, 0);
        step;
        chk("R9 override", {cyc_kind, arr_rd, addr_load, asleep}, {26'd0, 3'd7, 3'b000});
        @(negedge clk);
        drive(RD_BEGIN | 10'b0000000001);
        step;
        chk("R10 entered", {cyc_kind, asleep}, {28'd0, 3'd7, 1'b1});
        @(negedge clk);
        step;
        chk("R10 stays", {31'd0, asleep}, 1);
        // R11: recovery window
        @(negedge clk);
        drive(RD_BEGIN);
        step;
        chk("R11 w1", {cyc_kind, arr_rd, asleep}, {27'd0, 3'd7, 2'b00});
        @(negedge clk);
        step;
        chk("R11 w2", {cyc_kind, arr_rd, addr_load}, {27'd0, 3'd7, 2'b00});
        @(negedge clk);
        step;
        chk("R11 w3 normal", {cyc_kind, arr_rd, addr_load, bus_drive}, {26'd0, 3'd1, 3'b111});
        // R10: aborted entry; R9: history cleared, continue stays deselected
        @(negedge clk);
        drive(10'b0101111001);
        step;
        chk("R10 one edge", {cyc_kind, asleep}, {28'd0, 3'd7, 1'b0});
        @(negedge clk);
        drive(10'b0101111000);
        step;
        chk("R9 cleared history", {cyc_kind, arr_rd, burst_adv, asleep, bus_drive},
            {25'd0, 3'd0, 4'b0000});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule